// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the control and identification register file of a processor core module. A bus master reaches it over a simple single-cycle 32-bit bus with byte addresses: every access is one cycle long, writes take effect at the clock edge, and read data is combinational in the same cycle. Address bits [1:0] are ignored, so each register sits at a word index. Reads to addresses 0x100 through 0x1FF reach a read-only window onto the memory module's serial-presence data.

The block holds constant identity and status words. It has two oscillator settings that change only while a 16-bit lock key is loaded. A control register drives the boot-remap level and an LED, and it can issue a one-cycle reset request. Two flag registers are changed only through set and clear addresses. A 32-bit reference counter advances on an external tick enable, so its rate does not depend on the bus clock. The installed memory size is a parameter and is folded into the SDRAM register at reset. Any access to an address that is not mapped for its direction reads zero, changes nothing, and pulses an error strobe.

Top module: `cm_sysctl`

## Requirements
- R1: Reset values: word 0 reads 0x411A3001, word 4 reads 0x00100000, word 2 reads 0x01000048, word 7 reads 0x0007FEFF, word 9 reads 0x00000112, and word 8 reads 0x00011122 ORed with a size code: 0x10 for MEM_MB ≥ 256, 0x0C for ≥ 128, 0x08 for ≥ 64, 0x04 for ≥ 32, and 0 below 32. Word 1 and words 32 to 35 read zero and ignore writes.
- R2: A write to word 5 stores the low 16 bits of the data. A read of word 5 returns 0x0001A05F when the stored value is 0xA05F, and otherwise returns the stored value zero-extended.
- R3: A write to word 2 or word 7 updates that register only while word 5 holds 0xA05F. Otherwise the register keeps its old value.
- R4: A write to word 3 stores data bits 0 and 2. A read of word 3 shows only those two bits.
- R5: Output `remap_o` equals control bit 2 (0 means flash is mapped at address zero, 1 means RAM is), and `led_o` equals control bit 0.
- R6: A write to word 3 with data bit 3 set raises `rst_req_o` for exactly the one cycle after the write. Bit 3 is never stored and always reads zero.
- R7: A write to word 12 ORs the data into the flags register, and a write to word 13 clears the bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags. Reads of word 12 and word 14 return the current values.
- R8: Word 10 reads a 32-bit count of the clock edges, since reset, at which `ref_tick_i` was high.
- R9: A read at byte address A in 0x100 to 0x17F returns, zero-extended, byte A/4 of a 128-entry presence table. Table bytes 73 to 83 hold the MODULE_NAME string, first character at byte 73, and all other table bytes read zero. Reads from 0x180 to 0x1FF return zero.
- R10: Words 8 and 9 take any written value.
- R11: An access that is not mapped for its direction reads zero, changes no state, and raises `bad_acc_o` for the one following cycle. Mapped for reads: words 0 to 5, 7 to 10, 12, 14, 32 to 35, and byte addresses 0x100 to 0x1FF. Mapped for writes: words 1 to 3, 5, 7 to 9, 12 to 15, and 32 to 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Reference-rate enable, one cycle per count |
| sel_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| remap_o | output | 1 | Boot remap level |
| led_o | output | 1 | LED drive |
| rst_req_o | output | 1 | One-cycle reset request |
| bad_acc_o | output | 1 | Unmapped-access strobe |

## Verification
The hardest condition to reach from the ports is an oscillator write that arrives after the lock key has been loaded and then replaced by a different value. That case needs a particular order of lock writes before the oscillator write. The random stimulus writes the key to the lock half of the time and another value the rest of the time, so locked and unlocked oscillator writes both occur many times. The bench also tracks `ref_tick_i` edge by edge, so each counter read can be compared exactly against the ticks applied since reset.

// File: rtl/cm_sysctl.sv
module cm_sysctl #(
  parameter int unsigned MEM_MB = 128,
  parameter logic [87:0] MODULE_NAME = "CORE-SDRAM1"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick_i,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [8:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        remap_o,
  output logic        led_o,
  output logic        rst_req_o,
  output logic        bad_acc_o
);
  localparam logic [31:0] ID_WORD   = 32'h411A3001;
  localparam logic [31:0] STAT_WORD = 32'h00100000;
  localparam logic [15:0] KEY       = 16'hA05F;
  localparam logic [31:0] SIZE_CODE = (MEM_MB >= 256) ? 32'h10 :
                                      (MEM_MB >= 128) ? 32'h0C :
                                      (MEM_MB >= 64)  ? 32'h08 :
                                      (MEM_MB >= 32)  ? 32'h04 : 32'h0;
  localparam logic [31:0] SDRAM_RST = 32'h00011122 | SIZE_CODE;
  localparam int unsigned NAME_LEN  = 11;
  localparam int unsigned NAME_LO   = 73 - 64;
  localparam int unsigned NAME_HI   = NAME_LO + NAME_LEN - 1;

  logic [31:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q, cnt_q;
  logic [15:0] lock_q;
  logic [1:0]  ctrl_q;
  logic [6:0]  word;
  logic [5:0]  spd_idx;
  logic [7:0]  spd_byte;
  logic        unlocked, rd_hit, wr_hit, wr;

  assign word     = addr_i[8:2];
  assign spd_idx  = addr_i[7:2];
  assign unlocked = (lock_q == KEY);
  assign wr       = sel_i & we_i & wr_hit;
  assign remap_o  = ctrl_q[1];
  assign led_o    = ctrl_q[0];

  always_comb begin
    spd_byte = 8'h00;
    if (spd_idx >= 6'(NAME_LO) && spd_idx <= 6'(NAME_HI))
      spd_byte = MODULE_NAME[8*(NAME_HI - 32'(spd_idx)) +: 8];
  end

  always_comb begin
    rd_hit  = 1'b1;
    rdata_o = '0;
    if (addr_i[8]) begin
      if (!addr_i[7]) rdata_o = {24'b0, spd_byte};
    end else begin
      case (word)
        7'd0:  rdata_o = ID_WORD;
        7'd1:  rdata_o = '0;
        7'd2:  rdata_o = osc_q;
        7'd3:  rdata_o = {29'b0, ctrl_q[1], 1'b0, ctrl_q[0]};
        7'd4:  rdata_o = STAT_WORD;
        7'd5:  rdata_o = unlocked ? 32'h0001A05F : {16'b0, lock_q};
        7'd7:  rdata_o = aux_q;
        7'd8:  rdata_o = sdram_q;
        7'd9:  rdata_o = init_q;
        7'd10: rdata_o = cnt_q;
        7'd12: rdata_o = flags_q;
        7'd14: rdata_o = nvflags_q;
        7'd32, 7'd33, 7'd34, 7'd35: rdata_o = '0;
        default: rd_hit = 1'b0;
      endcase
    end
    if (we_i) rdata_o = '0;
  end

  always_comb begin
    wr_hit = 1'b0;
    if (!addr_i[8]) begin
      case (word)
        7'd1, 7'd2, 7'd3, 7'd5, 7'd7, 7'd8, 7'd9,
        7'd12, 7'd13, 7'd14, 7'd15,
        7'd32, 7'd33, 7'd34, 7'd35: wr_hit = 1'b1;
        default: wr_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q     <= 32'h01000048;
      aux_q     <= 32'h0007FEFF;
      sdram_q   <= SDRAM_RST;
      init_q    <= 32'h00000112;
      lock_q    <= '0;
      ctrl_q    <= '0;
      flags_q   <= '0;
      nvflags_q <= '0;
      rst_req_o <= 1'b0;
      bad_acc_o <= 1'b0;
    end else begin
      rst_req_o <= wr && word == 7'd3 && wdata_i[3];
      bad_acc_o <= sel_i && (we_i ? !wr_hit : !rd_hit);
      if (wr) begin
        case (word)
          7'd2:  if (unlocked) osc_q <= wdata_i;
          7'd3:  ctrl_q <= {wdata_i[2], wdata_i[0]};
          7'd5:  lock_q <= wdata_i[15:0];
          7'd7:  if (unlocked) aux_q <= wdata_i;
          7'd8:  sdram_q <= wdata_i;
          7'd9:  init_q <= wdata_i;
          7'd12: flags_q <= flags_q | wdata_i;
          7'd13: flags_q <= flags_q & ~wdata_i;
          7'd14: nvflags_q <= nvflags_q | wdata_i;
          7'd15: nvflags_q <= nvflags_q & ~wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= cnt_q + 32'd1;
  end
endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_tick_i,
  input logic        sel_i,
  input logic        we_i,
  input logic [8:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        remap_o,
  input logic        rst_req_o,
  input logic        bad_acc_o,
  input logic [31:0] osc_q,
  input logic [31:0] aux_q,
  input logic [15:0] lock_q,
  input logic [31:0] cnt_q
);
  logic wr_osc, wr_ctl;
  assign wr_osc = sel_i && we_i && !addr_i[8] && (addr_i[7:2] == 6'd2 || addr_i[7:2] == 6'd7);
  assign wr_ctl = sel_i && we_i && !addr_i[8] && addr_i[7:2] == 6'd3;

  assert_lock_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !we_i && addr_i == 9'h014 && lock_q == 16'hA05F) |-> rdata_o == 32'h0001A05F);

  assert_locked_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_osc && lock_q != 16'hA05F) |=> ($stable(osc_q) && $stable(aux_q)));

  assert_remap_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> remap_o == $past(wdata_i[2]));

  assert_reset_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_reset_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata_i[3]) |=> rst_req_o);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick_i |=> cnt_q == $past(cnt_q) + 32'd1);

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick_i |=> $stable(cnt_q));

  assert_bad_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> !bad_acc_o);
endmodule

bind cm_sysctl cm_sysctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .sel_i(sel_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .remap_o(remap_o),
  .rst_req_o(rst_req_o), .bad_acc_o(bad_acc_o), .osc_q(osc_q), .aux_q(aux_q),
  .lock_q(lock_q), .cnt_q(cnt_q)
);

// File: tb/cm_sysctl_tb_top.sv
module cm_sysctl_tb_top;
  localparam logic [87:0] NAME = "CORE-SDRAM1";
  logic clk = 0, rst_n = 0, ref_tick_i = 0, sel_i = 0, we_i = 0;
  logic [8:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic remap_o, led_o, rst_req_o, bad_acc_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_cnt;
  logic [15:0] m_lock;
  logic [2:0]  m_ctrl;

  always #5 clk = ~clk;

  cm_sysctl dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit rd_ok(input logic [8:0] a);
    int w = a[8:2];
    if (a >= 9'h100) return 1;
    return (w <= 5) || (w >= 7 && w <= 10) || w == 12 || w == 14 || (w >= 32 && w <= 35);
  endfunction

  function automatic bit wr_ok(input logic [8:0] a);
    int w = a[8:2];
    if (a >= 9'h100) return 0;
    return (w >= 1 && w <= 3) || w == 5 || (w >= 7 && w <= 9) || (w >= 12 && w <= 15) || (w >= 32 && w <= 35);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    int w = a[8:2];
    if (!rd_ok(a)) return 0;
    if (a >= 9'h180) return 0;
    if (a >= 9'h100) begin
      if (w >= 73 && w <= 83) return {24'b0, NAME[8*(83-w) +: 8]};
      return 0;
    end
    case (w)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return {29'b0, m_ctrl};
      4: return 32'h00100000;
      5: return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'b0, m_lock};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      10: return m_cnt;
      12: return m_flags;
      14: return m_nv;
      default: return 0;
    endcase
  endfunction

  task automatic model_wr(input logic [8:0] a, input logic [31:0] d);
    int w = a[8:2];
    if (!wr_ok(a)) return;
    case (w)
      2: if (m_lock == 16'hA05F) m_osc = d;
      3: m_ctrl = {d[2], 1'b0, d[0]};
      5: m_lock = d[15:0];
      7: if (m_lock == 16'hA05F) m_aux = d;
      8: m_sdram = d;
      9: m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      default: ;
    endcase
  endtask

  task automatic access(input string req, input logic w, input logic [8:0] a, input logic [31:0] d);
    logic tick = ($urandom % 3) == 0;
    logic ok = w ? wr_ok(a) : rd_ok(a);
    sel_i = 1; we_i = w; addr_i = a; wdata_i = d; ref_tick_i = tick;
    #1;
    if (!w) check({req, " read"}, rdata_o, exp_rd(a));
    @(posedge clk);
    if (tick) m_cnt++;
    if (w) model_wr(a, d);
    @(negedge clk);
    sel_i = 0; we_i = 0; ref_tick_i = 0;
    check("R11 strobe", {31'b0, bad_acc_o}, {31'b0, !ok});
    check("R6 reset pulse", {31'b0, rst_req_o}, {31'b0, w && ok && a[8:2] == 3 && d[3]});
    check("R5 remap", {31'b0, remap_o}, {31'b0, m_ctrl[2]});
    check("R5 led", {31'b0, led_o}, {31'b0, m_ctrl[0]});
  endtask

  task automatic rd(input string req, input logic [8:0] a);
    access(req, 0, a, $urandom);
  endtask

  task automatic wrt(input string req, input logic [8:0] a, input logic [31:0] d);
    access(req, 1, a, d);
  endtask

  initial begin
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdram = 32'h0001112E;
    m_init = 32'h00000112; m_flags = 0; m_nv = 0; m_cnt = 0; m_lock = 0; m_ctrl = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset remap", {31'b0, remap_o}, 0);
    check("R6 reset req", {31'b0, rst_req_o}, 0);
    foreach (m_ctrl[i]) ;
    rd("R1 id", 9'h000); rd("R1 stat", 9'h010); rd("R1 osc", 9'h008);
    rd("R1 aux", 9'h01C); rd("R1 sdram", 9'h020); rd("R1 init", 9'h024);
    rd("R1 proc", 9'h004); rd("R1 volt", 9'h080);
    wrt("R3 locked osc", 9'h008, 32'hDEADBEEF); rd("R3", 9'h008);
    wrt("R2 lock", 9'h014, 32'hFFFFA05F); rd("R2", 9'h014);
    wrt("R3 open osc", 9'h008, 32'h12345678); rd("R3", 9'h008);
    wrt("R3 open aux", 9'h01C, 32'hCAFEF00D); rd("R3", 9'h01C);
    wrt("R2 relock", 9'h014, 32'h0000A05E); rd("R2", 9'h014);
    wrt("R3 relocked aux", 9'h01C, 32'h0); rd("R3", 9'h01C);
    wrt("R6 reset+remap", 9'h00C, 32'hFFFFFFFF); rd("R4 ctrl", 9'h00C);
    wrt("R4 ctrl clear", 9'h00C, 32'h00000008); rd("R4", 9'h00C);
    wrt("R7 set", 9'h030, 32'h0000F0F0); wrt("R7 clr", 9'h034, 32'h00003030); rd("R7", 9'h030);
    wrt("R7 nv set", 9'h038, 32'h80000001); wrt("R7 nv clr", 9'h03C, 32'h1); rd("R7", 9'h038);
    wrt("R10 sdram", 9'h020, 32'h55AA55AA); rd("R10", 9'h020);
    wrt("R1 volt wr", 9'h084, 32'hFFFFFFFF); rd("R1 volt", 9'h084);
    for (int i = 0; i < 32; i++) rd("R9 spd", 9'h100 + 9'(4*i));
    rd("R9 spd high", 9'h180); rd("R9 spd top", 9'h1FC);
    wrt("R11 spd write", 9'h124, 32'h1); rd("R11 lmcnt", 9'h018); rd("R11 clr rd", 9'h034);
    wrt("R11 stat write", 9'h010, 32'h1); rd("R1 stat", 9'h010);
    rd("R8 count", 9'h028);
    for (int i = 0; i < 2000; i++) begin
      logic [8:0] a;
      logic [31:0] d = $urandom;
      int p = $urandom % 10;
      if (p < 2) a = 9'h014;
      else if (p < 5) a = {2'b0, 5'($urandom % 16), 2'b0};
      else if (p < 6) a = 9'h028;
      else a = 9'($urandom);
      if (a == 9'h014 && ($urandom % 2)) d = 32'h0000A05F;
      if ($urandom % 2) wrt("R3 random", a, d);
      else rd("R8 random", a);
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (100000) @(posedge clk);
            n_chk++; n_bad++; $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule